// File: doc/BRIEF.md
# Processor Tick Timer

This block is a cycle-counting timer meant to sit beside a processor core. It is read and written through a small register port. It has three registers. The count register is 32 bits wide and advances once per clock. The mode register packs together a run mode, an interrupt enable, a sticky pending flag and a 28-bit match period. A read-only capability word tells software that the timer is fitted. Whenever the low 28 bits of the count equal the period, a match occurs. A match sets the pending flag and, if the enable is set, drives the interrupt output.

A small controller with five states sets what the counter does on each clock:

- `TS_OFF`: the counter holds and matching is off.
- `TS_RESTART`: the counter counts up and returns to zero on a match.
- `TS_SINGLE`: the counter counts up until a match.
- `TS_SINGLE_DONE`: the counter is parked after a single-run match and matching is off.
- `TS_FREE`: the counter runs on and ignores matches.

A mode-register write moves the controller to the state selected by the written mode field: 00 goes to `TS_OFF`, 01 to `TS_RESTART`, 10 to `TS_SINGLE` and 11 to `TS_FREE`. This happens from any state. The only transition not caused by a write is `TS_SINGLE` to `TS_SINGLE_DONE`, which is taken on a match.

A typical use is to read the count, add a delta, keep the low 28 bits, and write the result as the period with the mode set to free-running and the enable set. The interrupt then arrives when the count reaches that point. To acknowledge it, software writes the mode register with only the mode bits set.

Top module: `tick_timer_unit`

## Requirements
- R1: After reset the count register (address 0) reads 0, the mode register (address 1) reads 0, and `irq_o` is 0.
- R2: In free-running mode (mode field 11), with no count write, the count rises by exactly 1 on every clock. It wraps from 0xFFFFFFFF to 0, and it runs straight through a match.
- R3: A match is detected in any clock where the controller is in `TS_RESTART`, `TS_SINGLE` or `TS_FREE` and count[27:0] equals the period. Count bits 31:28 take no part in the comparison. A match sets pending (mode register bit 28) at the end of that clock.
- R4: `irq_o` is a registered level. After every clock it equals pending AND enable (mode register bit 29).
- R5: Pending is sticky. It changes only through a mode-register write, which loads it from write-data bit 28. A match in the same clock as a write of 0 leaves pending set.
- R6: Writing 0xC0000000 to the mode register clears pending and enable, drops `irq_o` after that clock, and leaves the counter running.
- R7: In restart mode (mode field 01) the count becomes 0 on the clock after it equals the period. Otherwise it counts up.
- R8: In single-run mode (mode field 10) the count stops at the matching value. After that the counter holds, including at any newly written count value, and no match is detected until the mode register is written again. The mode field still reads 10.
- R9: In disabled mode (mode field 00) the count holds and no match is detected, even when count[27:0] equals the period.
- R10: A count-register write appears in the count on the next clock, and that clock's mode-driven update is dropped.
- R11: Address 2 reads as a word with only bit 10 set (timer present). Address 3 reads 0.
- R12: The mode register reads back as {mode[31:30], enable[29], pending[28], period[27:0]}, holding what was last written when no match has occurred since.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock; the count advances on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe, one write per asserted clock |
| reg_addr | input | 2 | Register select: 0 count, 1 mode, 2 capability |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register (combinational) |
| irq_o | output | 1 | Timer interrupt level |

## Verification
The compare is tried in several ways. Counts with zero upper bits are matched against small periods. A count with nonzero bits 31:28 is matched to show that those bits are ignored. A count written near the 32-bit limit shows the wrap, and shows that a free-running match does not disturb counting. A clearing write is placed in exactly the clock where the count equals the period, which separates "match wins" from "write wins". The same period is run in restart, single-run and disabled modes: one counter value against one period then gives three distinct count traces. A count written into the parked single-run state shows that the stop persists.

// File: rtl/tt_pkg.sv
package tt_pkg;

    typedef enum logic [2:0] {
        TS_OFF,
        TS_RESTART,
        TS_SINGLE,
        TS_SINGLE_DONE,
        TS_FREE
    } tt_state_e;

    typedef enum logic [1:0] {
        CA_HOLD,
        CA_INC,
        CA_CLEAR
    } cnt_act_e;

    localparam logic [1:0] MODE_OFF     = 2'b00;
    localparam logic [1:0] MODE_RESTART = 2'b01;
    localparam logic [1:0] MODE_SINGLE  = 2'b10;
    localparam logic [1:0] MODE_FREE    = 2'b11;

    localparam logic [1:0] ADDR_COUNT = 2'd0;
    localparam logic [1:0] ADDR_MODE  = 2'd1;
    localparam logic [1:0] ADDR_CAP   = 2'd2;

endpackage

// File: rtl/tt_mode_fsm.sv
module tt_mode_fsm
    import tt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_wr,
    input  logic [1:0] mode_wdata,
    input  logic       match,
    output logic       armed_o,
    output cnt_act_e   act_o,
    output logic [1:0] mode_rd_o
);

    tt_state_e state_q;
    tt_state_e state_d;

    // next-state selection
    always_comb begin
        state_d = state_q;
        if (mode_wr) begin
            unique case (mode_wdata)
                MODE_OFF:     state_d = TS_OFF;
                MODE_RESTART: state_d = TS_RESTART;
                MODE_SINGLE:  state_d = TS_SINGLE;
                MODE_FREE:    state_d = TS_FREE;
                default:      state_d = TS_OFF;
            endcase
        end else if (state_q == TS_SINGLE && match) begin
            state_d = TS_SINGLE_DONE;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TS_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // per-state outputs
    always_comb begin
        armed_o   = 1'b0;
        act_o     = CA_HOLD;
        mode_rd_o = MODE_OFF;
        unique case (state_q)
            TS_OFF: begin
                armed_o   = 1'b0;
                act_o     = CA_HOLD;
                mode_rd_o = MODE_OFF;
            end
            TS_RESTART: begin
                armed_o   = 1'b1;
                act_o     = match ? CA_CLEAR : CA_INC;
                mode_rd_o = MODE_RESTART;
            end
            TS_SINGLE: begin
                armed_o   = 1'b1;
                act_o     = match ? CA_HOLD : CA_INC;
                mode_rd_o = MODE_SINGLE;
            end
            TS_SINGLE_DONE: begin
                armed_o   = 1'b0;
                act_o     = CA_HOLD;
                mode_rd_o = MODE_SINGLE;
            end
            TS_FREE: begin
                armed_o   = 1'b1;
                act_o     = CA_INC;
                mode_rd_o = MODE_FREE;
            end
            default: begin
                armed_o   = 1'b0;
                act_o     = CA_HOLD;
                mode_rd_o = MODE_OFF;
            end
        endcase
    end

    // R8
    done_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TS_SINGLE_DONE && !mode_wr) |=> (state_q == TS_SINGLE_DONE));

    // R8
    single_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TS_SINGLE && match && !mode_wr) |=> (state_q == TS_SINGLE_DONE));

    // R9
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TS_OFF) |-> (act_o == CA_HOLD));

endmodule

// File: rtl/tt_counter.sv
module tt_counter
    import tt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  cnt_act_e         act,
    output logic [CNT_W-1:0] count_o
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (cnt_wr) begin
            count_q <= cnt_wdata;
        end else begin
            unique case (act)
                CA_HOLD:  count_q <= count_q;
                CA_INC:   count_q <= count_q + ONE;
                CA_CLEAR: count_q <= '0;
                default:  count_q <= count_q;
            endcase
        end
    end

    assign count_o = count_q;

    // R10
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (count_q == $past(cnt_wdata)));

    // R2
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act == CA_INC && !cnt_wr) |=> (count_q == $past(count_q) + ONE));

    // R9
    hold_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act == CA_HOLD && !cnt_wr) |=> $stable(count_q));

    // R7
    restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act == CA_CLEAR && !cnt_wr) |=> (count_q == '0));

endmodule

// File: rtl/tt_match_pend.sv
module tt_match_pend #(
    parameter int PER_W = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PER_W-1:0] cnt_lo,
    input  logic             armed,
    input  logic             mode_wr,
    input  logic             wr_ie,
    input  logic             wr_ip,
    input  logic [PER_W-1:0] wr_period,
    output logic             match_o,
    output logic             ie_o,
    output logic             ip_o,
    output logic [PER_W-1:0] period_o,
    output logic             irq_o
);

    logic             ie_q, ip_q, irq_q;
    logic [PER_W-1:0] period_q;
    logic             ie_d, ip_d;

    assign match_o = armed && (cnt_lo == period_q);

    always_comb begin
        ie_d = mode_wr ? wr_ie : ie_q;
        ip_d = (mode_wr ? wr_ip : ip_q) | match_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie_q     <= 1'b0;
            ip_q     <= 1'b0;
            irq_q    <= 1'b0;
            period_q <= '0;
        end else begin
            ie_q  <= ie_d;
            ip_q  <= ip_d;
            irq_q <= ie_d & ip_d;
            if (mode_wr) begin
                period_q <= wr_period;
            end
        end
    end

    assign ie_o     = ie_q;
    assign ip_o     = ip_q;
    assign period_o = period_q;
    assign irq_o    = irq_q;

    // R5
    pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ip_q && !mode_wr) |=> ip_q);

    // R3
    match_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |=> ip_q);

    // R4
    irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q == (ip_q && ie_q));

    // R12
    period_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_wr |=> $stable(period_q));

endmodule

// File: rtl/tick_timer_unit.sv
module tick_timer_unit
    import tt_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int PER_W   = 28,
    parameter int CAP_BIT = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr_en,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq_o
);

    localparam int IP_BIT  = PER_W;
    localparam int IE_BIT  = PER_W + 1;
    localparam int MODE_LO = PER_W + 2;

    logic             cnt_wr, mode_wr;
    logic [CNT_W-1:0] count;
    logic             armed, match, ie, ip;
    logic [PER_W-1:0] period;
    logic [1:0]       mode_rd;
    cnt_act_e         act;

    assign cnt_wr  = reg_wr_en && (reg_addr == ADDR_COUNT);
    assign mode_wr = reg_wr_en && (reg_addr == ADDR_MODE);

    tt_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_wr    (mode_wr),
        .mode_wdata (reg_wdata[MODE_LO +: 2]),
        .match      (match),
        .armed_o    (armed),
        .act_o      (act),
        .mode_rd_o  (mode_rd)
    );

    tt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_wr    (cnt_wr),
        .cnt_wdata (reg_wdata[CNT_W-1:0]),
        .act       (act),
        .count_o   (count)
    );

    tt_match_pend #(.PER_W(PER_W)) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_lo    (count[PER_W-1:0]),
        .armed     (armed),
        .mode_wr   (mode_wr),
        .wr_ie     (reg_wdata[IE_BIT]),
        .wr_ip     (reg_wdata[IP_BIT]),
        .wr_period (reg_wdata[PER_W-1:0]),
        .match_o   (match),
        .ie_o      (ie),
        .ip_o      (ip),
        .period_o  (period),
        .irq_o     (irq_o)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_COUNT: reg_rdata[CNT_W-1:0] = count;
            ADDR_MODE: begin
                reg_rdata[MODE_LO +: 2]  = mode_rd;
                reg_rdata[IE_BIT]        = ie;
                reg_rdata[IP_BIT]        = ip;
                reg_rdata[PER_W-1:0]     = period;
            end
            ADDR_CAP:   reg_rdata[CAP_BIT] = 1'b1;
            default:    reg_rdata = '0;
        endcase
    end

    // R6
    quiet_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && !reg_wdata[IE_BIT]) |=> !irq_o);

    // R4
    irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (ie && ip));

endmodule

// File: tb/tick_timer_unit_tb.sv
module tick_timer_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    running = 1'b0;
    bit    finished = 1'b0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    tick_timer_unit u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr_en (wr),
        .reg_addr  (addr),
        .reg_wdata (wdata),
        .reg_rdata (rdata),
        .irq_o     (irq)
    );

    // behavioural reference: 0 off, 1 restart, 2 single, 3 free, 4 parked
    logic [31:0] m_cnt;
    int          m_st;
    bit          m_ie, m_ip, m_irq;
    logic [27:0] m_per;

    always @(posedge clk) begin
        bit          hit;
        logic [31:0] nc;
        int          ns;
        bit          nie, nip;
        logic [27:0] np;
        if (!rst_n) begin
            m_cnt = '0; m_st = 0; m_ie = 0; m_ip = 0; m_irq = 0; m_per = '0;
        end else begin
            hit = (m_st >= 1 && m_st <= 3) && (m_cnt[27:0] == m_per);
            nc = m_cnt;
            if (m_st == 1) nc = hit ? 32'd0 : m_cnt + 32'd1;
            else if (m_st == 2) nc = hit ? m_cnt : m_cnt + 32'd1;
            else if (m_st == 3) nc = m_cnt + 32'd1;
            if (wr && addr == 2'd0) nc = wdata;
            ns = m_st;
            if (m_st == 2 && hit) ns = 4;
            nie = m_ie; nip = m_ip; np = m_per;
            if (wr && addr == 2'd1) begin
                ns  = (wdata[31:30] == 2'b00) ? 0 : (wdata[31:30] == 2'b01) ? 1 :
                      (wdata[31:30] == 2'b10) ? 2 : 3;
                nie = wdata[29];
                nip = wdata[28];
                np  = wdata[27:0];
            end
            if (hit) nip = 1'b1;
            m_cnt = nc; m_st = ns; m_ie = nie; m_ip = nip; m_per = np;
            m_irq = nie & nip;
        end
    end

    function automatic logic [31:0] model_read(input logic [1:0] a);
        logic [1:0] mf;
        mf = (m_st == 4) ? 2'b10 : 2'(m_st);
        case (a)
            2'd0:    return m_cnt;
            2'd1:    return {mf, m_ie, m_ip, m_per};
            2'd2:    return 32'h0000_0400;
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // compare against the reference every clock, mid-cycle
    always @(negedge clk) begin
        if (running && !finished) begin
            check(cur_req, rdata, model_read(addr));
            check({cur_req, " irq"}, {31'b0, irq}, {31'b0, m_irq});
        end
    end

    task automatic step();
        @(posedge clk);
        #4;
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        step();
        wr = 1'b1; addr = a; wdata = d;
        step();
        wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [31:0] exp, input string req);
        addr = a;
        #2;
        check(req, rdata, exp);
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] c1;
        repeat (3) step();
        rst_n = 1'b1;
        running = 1'b1;

        cur_req = "R1";
        rd_chk(2'd0, 32'h0, "R1");
        rd_chk(2'd1, 32'h0, "R1");
        check("R1 irq", {31'b0, irq}, 32'h0);

        cur_req = "R11";
        rd_chk(2'd2, 32'h0000_0400, "R11");
        rd_chk(2'd3, 32'h0, "R11");

        cur_req = "R12";
        wr_reg(2'd1, 32'h2ABC_DEF1);
        rd_chk(2'd1, 32'h2ABC_DEF1, "R12");
        wr_reg(2'd1, 32'h3ABC_DEF1);
        rd_chk(2'd1, 32'h3ABC_DEF1, "R12");
        check("R4 irq set by enabled pending", {31'b0, irq}, 32'h1);

        cur_req = "R9";
        wr_reg(2'd1, 32'h0000_0000);
        repeat (5) step();
        rd_chk(2'd0, 32'h0, "R9");
        rd_chk(2'd1, 32'h0, "R9");

        cur_req = "R10";
        wr_reg(2'd0, 32'hFFFF_FFFD);
        rd_chk(2'd0, 32'hFFFF_FFFD, "R10");

        cur_req = "R2";
        wr_reg(2'd1, 32'hC000_0005);
        repeat (3) step();
        rd_chk(2'd0, 32'h0, "R2");
        repeat (6) step();
        rd_chk(2'd1, 32'hD000_0005, "R3");
        check("R4 no irq without enable", {31'b0, irq}, 32'h0);
        rd_chk(2'd0, 32'h6, "R2");

        cur_req = "R5";
        repeat (4) step();
        rd_chk(2'd1, 32'hD000_0005, "R5");
        wr_reg(2'd1, 32'hE000_0005);
        rd_chk(2'd1, 32'hE000_0005, "R5");

        cur_req = "R3";
        wr_reg(2'd0, 32'hF000_0003);
        repeat (3) step();
        rd_chk(2'd1, 32'hF000_0005, "R3");
        check("R4 irq on enabled match", {31'b0, irq}, 32'h1);
        rd_chk(2'd0, 32'hF000_0006, "R3");

        cur_req = "R10";
        wr_reg(2'd0, 32'hF000_0100);
        rd_chk(2'd0, 32'hF000_0100, "R10");
        step();
        rd_chk(2'd0, 32'hF000_0101, "R10");

        cur_req = "R6";
        wr_reg(2'd1, 32'hC000_0000);
        rd_chk(2'd1, 32'hC000_0000, "R6");
        check("R6 irq dropped", {31'b0, irq}, 32'h0);
        rd_chk(2'd0, m_cnt, "R6");
        c1 = rdata;
        step();
        rd_chk(2'd0, c1 + 32'd1, "R6");

        cur_req = "R5";
        wr_reg(2'd0, 32'd100);
        wr_reg(2'd1, 32'hC000_0067);
        addr = 2'd0;
        #1;
        while (rdata !== 32'd103) step();
        wr = 1'b1; addr = 2'd1; wdata = 32'hC000_0067;
        step();
        wr = 1'b0;
        rd_chk(2'd1, 32'hD000_0067, "R5");

        cur_req = "R7";
        wr_reg(2'd1, 32'h4000_0003);
        wr_reg(2'd0, 32'h0);
        rd_chk(2'd0, 32'h0, "R7");
        repeat (4) step();
        rd_chk(2'd0, 32'h0, "R7");
        step();
        rd_chk(2'd0, 32'h1, "R7");
        rd_chk(2'd1, 32'h5000_0003, "R7");
        repeat (6) step();

        cur_req = "R8";
        wr_reg(2'd1, 32'h8000_0004);
        wr_reg(2'd0, 32'h0);
        repeat (7) step();
        rd_chk(2'd0, 32'h4, "R8");
        rd_chk(2'd1, 32'h9000_0004, "R8");
        wr_reg(2'd0, 32'h20);
        repeat (3) step();
        rd_chk(2'd0, 32'h20, "R8");
        wr_reg(2'd1, 32'h8000_0024);
        repeat (6) step();
        rd_chk(2'd0, 32'h24, "R8");
        rd_chk(2'd1, 32'h9000_0024, "R8");

        cur_req = "R9";
        wr_reg(2'd1, 32'h2000_0024);
        repeat (4) step();
        rd_chk(2'd1, 32'h2000_0024, "R9");
        rd_chk(2'd0, 32'h24, "R9");
        check("R9 irq quiet", {31'b0, irq}, 32'h0);

        step();
        finish_run();
    end

endmodule